// File: doc/BRIEF.md
# Fault Dictionary Diagnosis Matcher

This block locates faults after a test session by comparing the observed failure pattern with a stored fault dictionary. The dictionary holds one column per modelled fault. Bit i of a column is set when test pattern i exposes that fault. The host loads the columns through a write port, one fault at a time. It then presents an error vector in which bit i is set when the response to test i differed from the expected response, and pulses a start input.

The matcher scans the columns one per clock and collects every column that equals the error vector exactly. At the end of the scan it reports three things: a bitmap of the candidate faults, the number of candidates, and a class code. Exactly one candidate means the fault is located to a single site. Several candidates form a group that the tests cannot tell apart. No candidate means the observed result is not explained by the modelled fault set.

Top module: `fault_dict_matcher`

## Requirements
- R1: When `wr_en` is high and no scan is running, the column `wr_col` is stored for fault `wr_fault` at the clock edge. Bit i of a column is 1 exactly when test i detects that fault. After reset, every column is all zeros.
- R2: When `start` is high and `busy` is low, the error vector is captured and `busy` rises. `done` is high for exactly one cycle, in the cycle that follows the NUM_FAULTS-th clock edge after the edge that accepted `start`.
- R3: At `done`, bit j of `match_map` is 1 exactly when the stored column for fault j equals the captured error vector in every bit.
- R4: At `done`, `match_count` equals the number of set bits in `match_map`.
- R5: Exactly one matching column gives `match_class` = 2'b01 (single fault located).
- R6: Two or more matching columns give `match_class` = 2'b10, and every one of those faults is set in `match_map`.
- R7: No matching column gives `match_class` = 2'b00.
- R8: An all-zero error vector goes through the normal comparison. It matches exactly the all-zero (undetectable) columns, and reports no match when there are none.
- R9: While `busy` is high, `start` and `wr_en` are ignored. Changes on `err_vec` after capture do not affect the running scan.
- R10: Reset clears `busy`, `done`, `match_map`, `match_count` and `match_class` to zero. The result outputs hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Dictionary column write strobe |
| wr_fault | input | 4 | Fault index of the column being written |
| wr_col | input | 8 | Column data, one bit per test pattern |
| start | input | 1 | Begin a diagnosis scan |
| err_vec | input | 8 | Observed error vector, one bit per test pattern |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result-valid pulse |
| match_map | output | 16 | Candidate fault bitmap |
| match_count | output | 5 | Number of candidate faults |
| match_class | output | 2 | 00 none, 01 total, 10 partial |

## Verification
The hardest case to reach from the ports is a scan that is disturbed while it runs. To get there, the bench raises `start` again, writes a new column and flips `err_vec`, all in the first cycles of a scan. It then checks that the result still reflects the captured vector and the old table, and runs a follow-up scan to show that the write never landed. Partial matches are built by writing the same column into several fault slots. Undetectable faults are built by zeroing a column and scanning with an all-zero error vector, before and after that column exists.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

  typedef enum logic [1:0] {
    MC_NONE    = 2'b00,
    MC_TOTAL   = 2'b01,
    MC_PARTIAL = 2'b10
  } match_class_e;

  // Maps a candidate count onto the three-way diagnosis class.
  function automatic match_class_e classify(input int unsigned n);
    if (n == 0)      return MC_NONE;
    else if (n == 1) return MC_TOTAL;
    else             return MC_PARTIAL;
  endfunction

endpackage

// File: rtl/fdm_table.sv
module fdm_table #(
  parameter int NUM_TESTS  = 8,
  parameter int NUM_FAULTS = 16,
  localparam int FIDX_W = $clog2(NUM_FAULTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_acc,
  input  logic [FIDX_W-1:0]    wr_idx,
  input  logic [NUM_TESTS-1:0] wr_data,
  input  logic [FIDX_W-1:0]    rd_idx,
  output logic [NUM_TESTS-1:0] rd_data
);

  logic [NUM_TESTS-1:0] cols [NUM_FAULTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_FAULTS; j++) cols[j] <= '0;
    end else if (wr_acc) begin
      cols[wr_idx] <= wr_data;
    end
  end

  assign rd_data = cols[rd_idx];

endmodule

// File: rtl/fdm_scanner.sv
module fdm_scanner #(
  parameter int NUM_TESTS  = 8,
  parameter int NUM_FAULTS = 16,
  localparam int FIDX_W = $clog2(NUM_FAULTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_acc,
  input  logic [NUM_TESTS-1:0] err_in,
  output logic                 busy,
  output logic [FIDX_W-1:0]    idx,
  output logic                 last,
  output logic [NUM_TESTS-1:0] err_q
);

  localparam logic [FIDX_W-1:0] LAST_IDX = FIDX_W'(NUM_FAULTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      err_q <= '0;
    end else if (start_acc) begin
      busy  <= 1'b1;
      idx   <= '0;
      err_q <= err_in;
    end else if (busy) begin
      if (idx == LAST_IDX) busy <= 1'b0;
      else                 idx  <= idx + 1'b1;
    end
  end

  assign last = busy && (idx == LAST_IDX);

endmodule

// File: rtl/fdm_result.sv
module fdm_result
  import fdm_pkg::*;
#(
  parameter int NUM_FAULTS = 16,
  localparam int FIDX_W = $clog2(NUM_FAULTS),
  localparam int CNT_W  = $clog2(NUM_FAULTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  cmp_valid,
  input  logic [FIDX_W-1:0]     cmp_idx,
  input  logic                  cmp_last,
  input  logic                  hit,
  output logic                  done,
  output logic [NUM_FAULTS-1:0] match_map,
  output logic [CNT_W-1:0]      match_count,
  output logic [1:0]            match_class
);

  function automatic logic [CNT_W-1:0] ones(input logic [NUM_FAULTS-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int k = 0; k < NUM_FAULTS; k++) s = s + CNT_W'(v[k]);
    return s;
  endfunction

  logic [NUM_FAULTS-1:0] acc_map;
  logic [NUM_FAULTS-1:0] next_map;
  logic [CNT_W-1:0]      next_cnt;

  always_comb begin
    next_map          = acc_map;
    next_map[cmp_idx] = hit;
    next_cnt          = ones(next_map);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_map     <= '0;
      done        <= 1'b0;
      match_map   <= '0;
      match_count <= '0;
      match_class <= MC_NONE;
    end else begin
      done <= cmp_last;
      if (clear)          acc_map <= '0;
      else if (cmp_valid) acc_map <= next_map;
      if (cmp_last) begin
        match_map   <= next_map;
        match_count <= next_cnt;
        match_class <= classify(int'(next_cnt));
      end
    end
  end

endmodule

// File: rtl/fault_dict_matcher.sv
module fault_dict_matcher #(
  parameter int NUM_TESTS  = 8,
  parameter int NUM_FAULTS = 16,
  localparam int FIDX_W = $clog2(NUM_FAULTS),
  localparam int CNT_W  = $clog2(NUM_FAULTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [FIDX_W-1:0]     wr_fault,
  input  logic [NUM_TESTS-1:0]  wr_col,
  input  logic                  start,
  input  logic [NUM_TESTS-1:0]  err_vec,
  output logic                  busy,
  output logic                  done,
  output logic [NUM_FAULTS-1:0] match_map,
  output logic [CNT_W-1:0]      match_count,
  output logic [1:0]            match_class
);

  // Named internal events, visible to the bound checker.
  logic                 start_acc;
  logic                 wr_acc;
  logic                 scan_hit;
  logic                 scan_last;
  logic [FIDX_W-1:0]    scan_idx;
  logic [NUM_TESTS-1:0] scan_col;
  logic [NUM_TESTS-1:0] err_q;

  assign start_acc = start && !busy;
  assign wr_acc    = wr_en && !busy;
  assign scan_hit  = (scan_col == err_q);

  fdm_table #(.NUM_TESTS(NUM_TESTS), .NUM_FAULTS(NUM_FAULTS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_acc  (wr_acc),
    .wr_idx  (wr_fault),
    .wr_data (wr_col),
    .rd_idx  (scan_idx),
    .rd_data (scan_col)
  );

  fdm_scanner #(.NUM_TESTS(NUM_TESTS), .NUM_FAULTS(NUM_FAULTS)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .err_in    (err_vec),
    .busy      (busy),
    .idx       (scan_idx),
    .last      (scan_last),
    .err_q     (err_q)
  );

  fdm_result #(.NUM_FAULTS(NUM_FAULTS)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start_acc),
    .cmp_valid   (busy),
    .cmp_idx     (scan_idx),
    .cmp_last    (scan_last),
    .hit         (scan_hit),
    .done        (done),
    .match_map   (match_map),
    .match_count (match_count),
    .match_class (match_class)
  );

endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int NUM_FAULTS = 16,
  parameter int FIDX_W     = 4,
  parameter int CNT_W      = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  done,
  input logic                  start_acc,
  input logic                  scan_last,
  input logic [NUM_FAULTS-1:0] match_map,
  input logic [CNT_W-1:0]      match_count,
  input logic [1:0]            match_class
);

  logic [FIDX_W-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (start_acc) busy_cnt <= '0;
    else if (busy)      busy_cnt <= busy_cnt + 1'b1;
  end

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy); // R2
  AST_SCAN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    scan_last |-> busy_cnt == FIDX_W'(NUM_FAULTS - 1)); // R2
  AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_last |=> done && !busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_COUNT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> match_count == CNT_W'($countones(match_map))); // R4
  AST_CLASS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((match_class == 2'b01) == ($countones(match_map) == 1))); // R5
  AST_CLASS_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((match_class == 2'b10) == ($countones(match_map) > 1))); // R6
  AST_CLASS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((match_class == 2'b00) == (match_map == '0))); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_acc); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(match_map) && $stable(match_count) && $stable(match_class)); // R10

endmodule

bind fault_dict_matcher fdm_checker #(
  .NUM_FAULTS (NUM_FAULTS),
  .FIDX_W     (FIDX_W),
  .CNT_W      (CNT_W)
) u_fdm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .start_acc   (start_acc),
  .scan_last   (scan_last),
  .match_map   (match_map),
  .match_count (match_count),
  .match_class (match_class)
);

// File: tb/test_fault_dict_matcher.sv
module test_fault_dict_matcher;

  localparam int NT = 8;
  localparam int NF = 16;
  localparam int IW = 4;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_fault = '0;
  logic [NT-1:0] wr_col = '0;
  logic          start = 1'b0;
  logic [NT-1:0] err_vec = '0;
  logic          busy, done;
  logic [NF-1:0] match_map;
  logic [CW-1:0] match_count;
  logic [1:0]    match_class;

  int errors = 0;
  int checks = 0;
  logic [NT-1:0] model [NF];

  always #4 clk = ~clk;  // 125 MHz

  fault_dict_matcher #(.NUM_TESTS(NT), .NUM_FAULTS(NF)) i_fault_dict_matcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fault(wr_fault), .wr_col(wr_col),
    .start(start), .err_vec(err_vec), .busy(busy), .done(done),
    .match_map(match_map), .match_count(match_count), .match_class(match_class)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input int j, input logic [NT-1:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_fault = IW'(j); wr_col = c;
    @(negedge clk);
    wr_en = 1'b0;
    model[j] = c;
  endtask

  // One scan; when disturb is set, start/write/err_vec are driven during busy.
  task automatic scan(input logic [NT-1:0] e, input bit disturb, input string req);
    logic [NF-1:0] exp_map;
    int exp_cnt, exp_cls, n;
    exp_map = '0;
    for (int j = 0; j < NF; j++) if (model[j] == e) exp_map[j] = 1'b1;
    exp_cnt = 0;
    for (int j = 0; j < NF; j++) exp_cnt += int'(exp_map[j]);
    exp_cls = (exp_cnt == 0) ? 0 : ((exp_cnt == 1) ? 1 : 2);
    @(negedge clk);
    start = 1'b1; err_vec = e;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (disturb) begin
      start = 1'b1; wr_en = 1'b1; wr_fault = '0; wr_col = 8'hAA; err_vec = ~e;
    end
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      if (disturb && n == 3) begin start = 1'b0; wr_en = 1'b0; end
    end
    // done visible after the NF-th edge following the start edge
    chk(n == NF + 1, "R2", "done latency", n, NF + 1);
    chk(match_map == exp_map, "R3", "match_map", match_map, exp_map);
    chk(int'(match_count) == exp_cnt, "R4", "match_count", match_count, exp_cnt);
    chk(int'(match_class) == exp_cls, req, "match_class", match_class, exp_cls);
    @(negedge clk);
    chk(!done, "R2", "done one cycle", done, 0);
    chk(match_map == exp_map, "R10", "map hold", match_map, exp_map);
  endtask

  task automatic test_reset();
    chk(!busy && !done, "R10", "busy/done at reset", {busy, done}, 0);
    chk(match_map == '0 && match_count == '0 && match_class == 2'b00, "R10",
        "results at reset", match_map, 0);
  endtask

  task automatic test_hold();
    logic [NF-1:0] m; logic [CW-1:0] c; logic [1:0] k;
    m = match_map; c = match_count; k = match_class;
    repeat (6) @(negedge clk);
    chk(match_map == m && match_count == c && match_class == k, "R10",
        "results hold idle", match_map, m);
  endtask

  initial begin
    for (int j = 0; j < NF; j++) model[j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    scan(8'h00, 1'b0, "R8");                 // empty table: all 16 undetectable, partial
    for (int j = 0; j < NF; j++) load(j, NT'(j + 1));  // R1
    scan(8'h05, 1'b0, "R5");                 // R1 column 4 alone matches: total
    scan(8'hAA, 1'b0, "R7");                 // nothing matches
    load(9, 8'h05);
    load(12, 8'h05);
    scan(8'h05, 1'b0, "R6");                 // faults 4, 9, 12 indistinguishable
    scan(8'h00, 1'b0, "R8");                 // no zero column: no match
    load(3, 8'h00);
    scan(8'h00, 1'b0, "R8");                 // only fault 3 undetectable: total
    scan(8'h05, 1'b1, "R9");                 // disturbed scan keeps captured vector
    scan(8'hAA, 1'b0, "R9");                 // write during busy never landed
    test_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule